// File: doc/BRIEF.md
# Scaled Add/Subtract Integer ALU

This block is one 64-bit integer execution slice for register-operate instructions. It takes a 7-bit function code, a first operand A and a second operand B. Depending on a literal flag, B is either a register value or an 8-bit immediate. Each request produces one registered 64-bit result, a valid strobe and an overflow flag.

The slice supports quadword (64-bit) and longword (32-bit) add and subtract. It also supports forms that scale A by 4 or by 8 before the add or subtract. There are equality, unsigned and signed comparisons. Four trapping add and subtract codes compute the same values as their plain forms and also raise the overflow flag on signed overflow. Raising the trap itself, the register file and byte-wise comparison are handled elsewhere in the pipeline.

A request is accepted on any cycle in which `in_valid` is high. The result appears on the next cycle, so a new request can be issued every cycle.

Top module: `scaled_addsub_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the registers clear, so `out_valid`, `result` and `ovf` are 0 afterwards.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `result` and `ovf` keep their previous values.
- R3: Code 0x20 returns A+B and code 0x29 returns A-B, both as full 64-bit values that wrap modulo 2^64.
- R4: Code 0x00 (A+B) and code 0x09 (A-B) keep the low 32 bits of the 64-bit result and copy bit 31 into bits 63..32.
- R5: The scaled codes shift A left before the operation, and A stays the minuend in a subtraction. The shift is 2 for 0x02 and 0x22 (add) and for 0x0b and 0x2b (subtract). The shift is 3 for 0x12 and 0x32 (add) and for 0x1b and 0x3b (subtract). Codes 0x02, 0x0b, 0x12 and 0x1b also apply the longword truncation and sign extension of R4.
- R6: When `use_lit` is 1, the 8-bit `lit` value, zero-extended to 64 bits, replaces B in every operation, and `opb` has no effect.
- R7: The unsigned and equality compares write 1 or 0 into bit 0 and zero into bits 63..1. Code 0x1d tests A<B unsigned, code 0x3d tests A<=B unsigned, and code 0x2d tests A==B.
- R8: Code 0x4d tests A<B and code 0x6d tests A<=B, both with A and B taken as signed two's-complement 64-bit values. The output is 1 or 0 in bit 0 and zero elsewhere.
- R9: Code 0x40 gives the result of 0x00 and code 0x49 gives the result of 0x09, and both set `ovf` when the 32-bit signed operation overflows. Code 0x60 gives the result of 0x20 and code 0x69 gives the result of 0x29, and both set `ovf` when the 64-bit signed operation overflows.
- R10: `ovf` is 0 for every code other than 0x40, 0x49, 0x60 and 0x69, even when the arithmetic would overflow.
- R11: A code not listed above, such as 0x0f or 0x7f, still produces `out_valid`, with `result` 0 and `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| func | input | 7 | Function code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Register operand B |
| lit | input | 8 | Immediate literal |
| use_lit | input | 1 | Select the literal instead of `opb` |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered result |
| ovf | output | 1 | Signed overflow on the trapping codes |

## Verification
The bench aims at carries that cross bit 31.

- A longword path that forgets to sign-extend returns 0x0000_0000_8000_0000 where 0xFFFF_FFFF_8000_0000 is expected.
- A path that forgets to truncate leaks upper bits of A into the result.
- A scaled subtract with its operands swapped, or with the wrong shift amount, returns a value of the wrong magnitude or sign.

The compare tests use operands whose unsigned and signed order disagree, so mixing up the two compare flavours flips bit 0. The literal tests use a literal of 0x80 and above, so sign-extending it instead of zero-extending it changes the answer. Overflow inputs are applied to both the plain and the trapping codes, which catches a flag that is missing or not gated by the code.

// File: rtl/scaled_alu_pkg.sv
package scaled_alu_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ADD  = 2'd1,
    KIND_SUB  = 2'd2,
    KIND_CMP  = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_ULT = 3'd1,
    REL_ULE = 3'd2,
    REL_SLT = 3'd3,
    REL_SLE = 3'd4
  } rel_e;

  typedef struct packed {
    op_kind_e   kind;
    rel_e       rel;
    logic [1:0] shamt;
    logic       quad;
    logic       trap;
  } alu_ctl_t;

  localparam int unsigned FUNC_W = 7;

  localparam logic [FUNC_W-1:0] F_ADDL   = 7'h00;
  localparam logic [FUNC_W-1:0] F_S4ADDL = 7'h02;
  localparam logic [FUNC_W-1:0] F_SUBL   = 7'h09;
  localparam logic [FUNC_W-1:0] F_S4SUBL = 7'h0b;
  localparam logic [FUNC_W-1:0] F_S8ADDL = 7'h12;
  localparam logic [FUNC_W-1:0] F_S8SUBL = 7'h1b;
  localparam logic [FUNC_W-1:0] F_CMPULT = 7'h1d;
  localparam logic [FUNC_W-1:0] F_ADDQ   = 7'h20;
  localparam logic [FUNC_W-1:0] F_S4ADDQ = 7'h22;
  localparam logic [FUNC_W-1:0] F_SUBQ   = 7'h29;
  localparam logic [FUNC_W-1:0] F_S4SUBQ = 7'h2b;
  localparam logic [FUNC_W-1:0] F_CMPEQ  = 7'h2d;
  localparam logic [FUNC_W-1:0] F_S8ADDQ = 7'h32;
  localparam logic [FUNC_W-1:0] F_S8SUBQ = 7'h3b;
  localparam logic [FUNC_W-1:0] F_CMPULE = 7'h3d;
  localparam logic [FUNC_W-1:0] F_ADDLV  = 7'h40;
  localparam logic [FUNC_W-1:0] F_SUBLV  = 7'h49;
  localparam logic [FUNC_W-1:0] F_CMPLT  = 7'h4d;
  localparam logic [FUNC_W-1:0] F_ADDQV  = 7'h60;
  localparam logic [FUNC_W-1:0] F_SUBQV  = 7'h69;
  localparam logic [FUNC_W-1:0] F_CMPLE  = 7'h6d;

endpackage

// File: rtl/scaled_decode.sv
module scaled_decode
  import scaled_alu_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output alu_ctl_t          ctl
);

  always_comb begin
    ctl = '{kind: KIND_NONE, rel: REL_EQ, shamt: 2'd0, quad: 1'b0, trap: 1'b0};
    unique case (func)
      F_ADDL:   ctl.kind = KIND_ADD;
      F_S4ADDL: begin ctl.kind = KIND_ADD; ctl.shamt = 2'd2; end
      F_S8ADDL: begin ctl.kind = KIND_ADD; ctl.shamt = 2'd3; end
      F_SUBL:   ctl.kind = KIND_SUB;
      F_S4SUBL: begin ctl.kind = KIND_SUB; ctl.shamt = 2'd2; end
      F_S8SUBL: begin ctl.kind = KIND_SUB; ctl.shamt = 2'd3; end
      F_ADDQ:   begin ctl.kind = KIND_ADD; ctl.quad = 1'b1; end
      F_S4ADDQ: begin ctl.kind = KIND_ADD; ctl.quad = 1'b1; ctl.shamt = 2'd2; end
      F_S8ADDQ: begin ctl.kind = KIND_ADD; ctl.quad = 1'b1; ctl.shamt = 2'd3; end
      F_SUBQ:   begin ctl.kind = KIND_SUB; ctl.quad = 1'b1; end
      F_S4SUBQ: begin ctl.kind = KIND_SUB; ctl.quad = 1'b1; ctl.shamt = 2'd2; end
      F_S8SUBQ: begin ctl.kind = KIND_SUB; ctl.quad = 1'b1; ctl.shamt = 2'd3; end
      F_ADDLV:  begin ctl.kind = KIND_ADD; ctl.trap = 1'b1; end
      F_SUBLV:  begin ctl.kind = KIND_SUB; ctl.trap = 1'b1; end
      F_ADDQV:  begin ctl.kind = KIND_ADD; ctl.quad = 1'b1; ctl.trap = 1'b1; end
      F_SUBQV:  begin ctl.kind = KIND_SUB; ctl.quad = 1'b1; ctl.trap = 1'b1; end
      F_CMPEQ:  begin ctl.kind = KIND_CMP; ctl.rel = REL_EQ;  end
      F_CMPULT: begin ctl.kind = KIND_CMP; ctl.rel = REL_ULT; end
      F_CMPULE: begin ctl.kind = KIND_CMP; ctl.rel = REL_ULE; end
      F_CMPLT:  begin ctl.kind = KIND_CMP; ctl.rel = REL_SLT; end
      F_CMPLE:  begin ctl.kind = KIND_CMP; ctl.rel = REL_SLE; end
      default:  ctl.kind = KIND_NONE;
    endcase
  end

endmodule

// File: rtl/scaled_arith.sv
module scaled_arith #(
  parameter int unsigned W  = 64,
  parameter int unsigned LW = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   shamt,
  input  logic         sub,
  input  logic         quad,
  output logic [W-1:0] res,
  output logic         sovf
);

  localparam int unsigned HI = W - LW;

  logic [W-1:0] a_sh;
  logic [W-1:0] raw;
  logic         sa, sb, sr;

  assign a_sh = a << shamt;
  assign raw  = sub ? (a_sh - b) : (a_sh + b);

  generate
    if (HI > 0) begin : g_split
      always_comb begin
        if (quad) res = raw;
        else      res = {{HI{raw[LW-1]}}, raw[LW-1:0]};
      end
    end else begin : g_flat
      assign res = raw;
    end
  endgenerate

  // sign bits of the lane in use
  assign sa = quad ? a_sh[W-1] : a_sh[LW-1];
  assign sb = quad ? b[W-1]    : b[LW-1];
  assign sr = quad ? raw[W-1]  : raw[LW-1];

  always_comb begin
    if (sub) sovf = (sa != sb) && (sr != sa);
    else     sovf = (sa == sb) && (sr != sa);
  end

endmodule

// File: rtl/scaled_compare.sv
module scaled_compare
  import scaled_alu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  rel_e         rel,
  output logic         hit
);

  logic eq, ult, slt;

  assign eq  = (a == b);
  assign ult = (a < b);
  assign slt = ($signed(a) < $signed(b));

  always_comb begin
    unique case (rel)
      REL_EQ:  hit = eq;
      REL_ULT: hit = ult;
      REL_ULE: hit = ult | eq;
      REL_SLT: hit = slt;
      REL_SLE: hit = slt | eq;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/scaled_addsub_alu.sv
module scaled_addsub_alu
  import scaled_alu_pkg::*;
#(
  parameter int unsigned W    = 64,
  parameter int unsigned LW   = 32,
  parameter int unsigned FW   = 7,
  parameter int unsigned LITW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [FW-1:0]   func,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [LITW-1:0] lit,
  input  logic            use_lit,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            ovf
);

  localparam int unsigned LIT_PAD = W - LITW;

  alu_ctl_t     ctl;
  logic [W-1:0] b_eff;
  logic [W-1:0] arith_res;
  logic         arith_ovf;
  logic         cmp_hit;
  logic [W-1:0] res_n;
  logic         ovf_n;

  scaled_decode u_dec (
    .func (func),
    .ctl  (ctl)
  );

  assign b_eff = use_lit ? {{LIT_PAD{1'b0}}, lit} : opb;

  scaled_arith #(.W(W), .LW(LW)) u_arith (
    .a     (opa),
    .b     (b_eff),
    .shamt (ctl.shamt),
    .sub   (ctl.kind == KIND_SUB),
    .quad  (ctl.quad),
    .res   (arith_res),
    .sovf  (arith_ovf)
  );

  scaled_compare #(.W(W)) u_cmp (
    .a   (opa),
    .b   (b_eff),
    .rel (ctl.rel),
    .hit (cmp_hit)
  );

  always_comb begin
    unique case (ctl.kind)
      KIND_ADD, KIND_SUB: res_n = arith_res;
      KIND_CMP:           res_n = {{(W-1){1'b0}}, cmp_hit};
      default:            res_n = '0;
    endcase
    ovf_n = ctl.trap & arith_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_n;
        ovf    <= ovf_n;
      end
    end
  end

endmodule

// File: rtl/scaled_addsub_alu_chk.sv
module scaled_addsub_alu_chk #(
  parameter int unsigned W    = 64,
  parameter int unsigned LW   = 32,
  parameter int unsigned FW   = 7,
  parameter int unsigned LITW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [FW-1:0]   func,
  input logic [W-1:0]    opa,
  input logic [W-1:0]    opb,
  input logic [LITW-1:0] lit,
  input logic            use_lit,
  input logic            out_valid,
  input logic [W-1:0]    result,
  input logic            ovf
);

  function automatic logic code_long(input logic [FW-1:0] f);
    return (f == 7'h00) || (f == 7'h02) || (f == 7'h09) || (f == 7'h0b) ||
           (f == 7'h12) || (f == 7'h1b) || (f == 7'h40) || (f == 7'h49);
  endfunction

  function automatic logic code_cmp(input logic [FW-1:0] f);
    return (f == 7'h1d) || (f == 7'h2d) || (f == 7'h3d) || (f == 7'h4d) || (f == 7'h6d);
  endfunction

  function automatic logic code_trap(input logic [FW-1:0] f);
    return (f == 7'h40) || (f == 7'h49) || (f == 7'h60) || (f == 7'h69);
  endfunction

  function automatic logic code_known(input logic [FW-1:0] f);
    return code_long(f) || code_cmp(f) ||
           (f == 7'h20) || (f == 7'h22) || (f == 7'h29) || (f == 7'h2b) ||
           (f == 7'h32) || (f == 7'h3b) || (f == 7'h60) || (f == 7'h69);
  endfunction

  logic unused_ok;
  assign unused_ok = ^{opa, opb, lit, use_lit};

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(ovf)));

  assert_long_sext_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && code_long(func)) |=> (result[W-1:LW] == {(W-LW){result[LW-1]}}));

  assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && code_cmp(func)) |=> (result[W-1:1] == '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !code_trap(func)) |=> !ovf);

  assert_unknown_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !code_known(func)) |=> (result == '0 && !ovf));

endmodule

bind scaled_addsub_alu scaled_addsub_alu_chk #(
  .W(W), .LW(LW), .FW(FW), .LITW(LITW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .func      (func),
  .opa       (opa),
  .opb       (opb),
  .lit       (lit),
  .use_lit   (use_lit),
  .out_valid (out_valid),
  .result    (result),
  .ovf       (ovf)
);

// File: tb/scaled_addsub_alu_test.sv
module scaled_addsub_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  func = '0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [7:0]  lit = '0;
  logic        use_lit = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        ovf;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;

  always #4 clk = ~clk;

  scaled_addsub_alu uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .func      (func),
    .opa       (opa),
    .opb       (opb),
    .lit       (lit),
    .use_lit   (use_lit),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one request, checked on the following cycle
  task automatic do_op(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] l, input logic ul,
                       input logic [63:0] exp_r, input logic exp_o, input string tag);
    @(negedge clk);
    func = f; opa = a; opb = b; lit = l; use_lit = ul; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " result"}, result, exp_r);
    check({tag, " ovf"}, {63'd0, ovf}, {63'd0, exp_o});
  endtask

  task automatic test_reset;
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    check("R1 result", result, 64'd0);
    check("R1 ovf", {63'd0, ovf}, 64'd0);
  endtask

  task automatic test_quad;
    do_op(7'h20, ALL1, 64'd2, 8'd0, 1'b0, 64'd1, 1'b0, "R3 addq wrap");
    do_op(7'h29, 64'd5, 64'd7, 8'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R3 subq borrow");
  endtask

  task automatic test_long;
    do_op(7'h00, 64'h7FFF_FFFF, 64'd1, 8'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, "R4 addl sext");
    do_op(7'h09, 64'h1_0000_0000, 64'd1, 8'd0, 1'b0, ALL1, 1'b0, "R4 subl trunc");
    do_op(7'h00, 64'hFFFF_FFFF_0000_0005, 64'd3, 8'd0, 1'b0, 64'd8, 1'b0, "R4 addl high drop");
  endtask

  task automatic test_scaled;
    do_op(7'h02, 64'd1, 64'd1, 8'd0, 1'b0, 64'd5, 1'b0, "R5 s4addl");
    do_op(7'h22, 64'd3, 64'd1, 8'd0, 1'b0, 64'd13, 1'b0, "R5 s4addq");
    do_op(7'h0b, 64'h4000_0000, 64'd0, 8'd0, 1'b0, 64'd0, 1'b0, "R5 s4subl trunc");
    do_op(7'h2b, 64'd5, 64'd30, 8'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF6, 1'b0, "R5 s4subq");
    do_op(7'h12, 64'h1000_0000, 64'd0, 8'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0, "R5 s8addl sext");
    do_op(7'h32, 64'd1, 64'd1, 8'd0, 1'b0, 64'd9, 1'b0, "R5 s8addq");
    do_op(7'h1b, 64'd4, 64'd2, 8'd0, 1'b0, 64'd30, 1'b0, "R5 s8subl");
    do_op(7'h3b, 64'd2, 64'd20, 8'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, "R5 s8subq");
  endtask

  task automatic test_literal;
    do_op(7'h20, 64'd1, 64'h1234, 8'hFF, 1'b1, 64'h100, 1'b0, "R6 addq literal");
    do_op(7'h1d, 64'h100, 64'd0, 8'h80, 1'b1, 64'd0, 1'b0, "R6 cmpult literal zext");
    do_op(7'h29, 64'd0, 64'd0, 8'h81, 1'b1, 64'hFFFF_FFFF_FFFF_FF7F, 1'b0, "R6 subq literal");
  endtask

  task automatic test_ucmp;
    do_op(7'h1d, 64'd1, ALL1, 8'd0, 1'b0, 64'd1, 1'b0, "R7 cmpult true");
    do_op(7'h1d, ALL1, 64'd1, 8'd0, 1'b0, 64'd0, 1'b0, "R7 cmpult false");
    do_op(7'h3d, 64'd9, 64'd9, 8'd0, 1'b0, 64'd1, 1'b0, "R7 cmpule equal");
    do_op(7'h3d, SMIN, SMAX, 8'd0, 1'b0, 64'd0, 1'b0, "R7 cmpule greater");
    do_op(7'h2d, 64'hABCD, 64'hABCD, 8'd0, 1'b0, 64'd1, 1'b0, "R7 cmpeq equal");
    do_op(7'h2d, 64'hABCD, 64'hABCE, 8'd0, 1'b0, 64'd0, 1'b0, "R7 cmpeq differ");
  endtask

  task automatic test_scmp;
    do_op(7'h4d, ALL1, 64'd1, 8'd0, 1'b0, 64'd1, 1'b0, "R8 cmplt negative");
    do_op(7'h4d, SMAX, SMIN, 8'd0, 1'b0, 64'd0, 1'b0, "R8 cmplt max vs min");
    do_op(7'h6d, 64'd1, ALL1, 8'd0, 1'b0, 64'd0, 1'b0, "R8 cmple false");
    do_op(7'h6d, SMIN, SMIN, 8'd0, 1'b0, 64'd1, 1'b0, "R8 cmple equal");
  endtask

  task automatic test_trap;
    do_op(7'h60, SMAX, 64'd1, 8'd0, 1'b0, SMIN, 1'b1, "R9 addqv overflow");
    do_op(7'h69, SMIN, 64'd1, 8'd0, 1'b0, SMAX, 1'b1, "R9 subqv overflow");
    do_op(7'h40, 64'h7FFF_FFFF, 64'd1, 8'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b1, "R9 addlv overflow");
    do_op(7'h49, 64'h8000_0000, 64'd1, 8'd0, 1'b0, 64'h7FFF_FFFF, 1'b1, "R9 sublv overflow");
    do_op(7'h49, 64'd5, 64'd3, 8'd0, 1'b0, 64'd2, 1'b0, "R9 sublv clean");
    do_op(7'h60, 64'd1, 64'd1, 8'd0, 1'b0, 64'd2, 1'b0, "R9 addqv clean");
  endtask

  task automatic test_no_trap;
    do_op(7'h20, SMAX, 64'd1, 8'd0, 1'b0, SMIN, 1'b0, "R10 addq no flag");
    do_op(7'h09, 64'h8000_0000, 64'd1, 8'd0, 1'b0, 64'h7FFF_FFFF, 1'b0, "R10 subl no flag");
  endtask

  task automatic test_unknown;
    do_op(7'h7f, 64'd7, 64'd7, 8'd0, 1'b0, 64'd0, 1'b0, "R11 code 7f");
    do_op(7'h0f, ALL1, 64'd0, 8'd0, 1'b0, 64'd0, 1'b0, "R11 code 0f");
  endtask

  task automatic test_hold;
    do_op(7'h60, SMAX, 64'd1, 8'd0, 1'b0, SMIN, 1'b1, "R2 setup");
    for (int i = 0; i < 3; i++) begin
      opa = 64'd100 + 64'(i); opb = 64'd3; func = 7'h20;
      @(negedge clk);
      check("R2 idle valid", {63'd0, out_valid}, 64'd0);
      check("R2 idle result", result, SMIN);
      check("R2 idle ovf", {63'd0, ovf}, 64'd1);
    end
  endtask

  task automatic test_stream;
    @(negedge clk);
    func = 7'h20; opa = 64'd10; opb = 64'd20; use_lit = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R2 stream first", result, 64'd30);
    func = 7'h29; opa = 64'd10; opb = 64'd4;
    @(negedge clk);
    check("R2 stream second", result, 64'd6);
    check("R2 stream valid", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 stream end", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    test_quad();
    test_long();
    test_scaled();
    test_literal();
    test_ucmp();
    test_scmp();
    test_trap();
    test_no_trap();
    test_unknown();
    test_hold();
    test_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule